// File: doc/BRIEF.md
# I2C Digital Potentiometer Register Controller

This block is the digital side of a 128-position potentiometer: an I2C target that holds the wiper code and drives a one-hot tap select. SCL and SDA arrive as sampled inputs. The block pulls SDA low through a separate drive-low output, so the pad stays an open-drain pad. Two strap inputs fill the low bits of the 7-bit device address, so four of these blocks can share one bus.

It keeps three registers:
- a volatile wiper register that drives the taps;
- a stand-in for a nonvolatile initial value register;
- an access control register with one meaningful bit, the volatile-only bit.

A write to the wiper address goes only to the wiper when the volatile-only bit is set. Otherwise it goes to both registers, and after the STOP a busy timer runs to model the slow nonvolatile store. While that timer runs, the block ignores its address.

There are two resets:
- A warm reset reloads the wiper from the stored initial value.
- A power-on reset also sets the stored value to its build-time default.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: The block acknowledges only a device address byte of 0,1,0,1,0,strap[1],strap[0] (MSB first) followed by the R/W bit (1 = read). To acknowledge, it drives SDA low during the ninth clock. It also acknowledges every byte that is written to it.
- R2: When bit 7 of the access control register is 1, a write to register 00h changes the wiper register only. The initial value register keeps its value.
- R3: When bit 7 of the access control register is 0, a write to register 00h stores the code into both the wiper and the initial value registers.
- R4: Register 02h is the access control register. A write keeps data bit 7, and a read returns that bit in bit 7 with bits 6..0 as 0.
- R5: A read is done as follows:
  - a write transaction sends the register pointer;
  - a repeated START carries the read address;
  - the block returns 8 bits, MSB first.
  Register 00h reads the wiper register when the volatile-only bit is 1, and the initial value register when it is 0.
- R6: Bit 7 of data written to register 00h is ignored, and register 00h always reads back with bit 7 equal to 0.
- R7: A write to any register address other than 00h or 02h is acknowledged and has no effect. A read of such an address returns 00h.
- R8: A write that reaches the initial value register starts a busy period of NV_BUSY_CYCLES clocks at the following STOP. During that period:
  - the device address is not acknowledged;
  - the wiper register stays unchanged.
  After the period ends, the address is acknowledged again.
- R9: Warm reset (rst_n low) loads the wiper from the initial value register and clears the access control register. Power-on reset (por_n low) sets both the initial value and the wiper registers to IVR_DEFAULT.
- R10: tap_sel_o has exactly one bit set, at the index equal to wiper_o. This holds for codes 0 through 127.
- R11: After the last read data bit, the block releases SDA. When the master answers with a NACK, the block keeps SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are sampled on it |
| por_n | input | 1 | Power-on reset, active low, synchronous; sets the stored initial value to its default |
| rst_n | input | 1 | Warm reset, active low, synchronous; reloads the wiper from the stored value |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_low_o | output | 1 | Pulls the SDA pad low when 1 |
| strap_i | input | 2 | Address straps, forming the two lowest address bits |
| wiper_o | output | 7 | Current wiper code |
| tap_sel_o | output | 128 | One-hot tap select decoded from the wiper code |

## Verification
The bench builds the block with NV_BUSY_CYCLES set to 400 instead of the default of about 12 ms of clocks. With that value, a single transaction sent right after a nonvolatile write still falls inside the busy window, and the end of the window can be reached within a short run. TAPS and IVR_DEFAULT keep their defaults of 128 and 64. This puts the first and last taps, the power-on default code and the full 7-bit range all within reach of the checks.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam logic [7:0] REG_WIPER = 8'h00;
  localparam logic [7:0] REG_CTRL  = 8'h02;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ADDR,
    LS_AACK,
    LS_WBIT,
    LS_WACK,
    LS_RBIT,
    LS_RACK
  } link_st_t;

  // Address byte matches the fixed upper bits plus the straps (bit 0 is R/W).
  function automatic logic addr_hit(input logic [7:0] b, input logic [4:0] hi,
                                    input logic [1:0] strap);
    return b[7:1] == {hi, strap};
  endfunction

  // A data write at the wiper address also commits the stored value when
  // the volatile-only bit is clear.
  function automatic logic nv_commit(input logic vol_only);
    return !vol_only;
  endfunction

endpackage

// File: rtl/dpot_i2c_link.sv
module dpot_i2c_link
  import dpot_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       busy_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_low_o,
  output logic       rx_valid_o,
  output logic       rx_first_o,
  output logic [7:0] rx_data_o,
  output logic       stop_o
);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, rise_c, fall_c;

  link_st_t   st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw, first, m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise_c  = scl_s & ~scl_q;
  assign fall_c  = ~scl_s & scl_q;
  assign stop_o  = stop_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= LS_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      rw         <= 1'b0;
      first      <= 1'b0;
      m_ack      <= 1'b0;
      sda_low_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_first_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (start_c) begin
        st        <= LS_ADDR;
        cnt       <= '0;
        sda_low_o <= 1'b0;
      end else if (stop_c) begin
        st        <= LS_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        case (st)
          LS_ADDR: begin
            if (rise_c && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (fall_c && cnt == 4'd8) begin
              if (addr_hit(shreg, ADDR_HI, strap_i) && !busy_i) begin
                st        <= LS_AACK;
                sda_low_o <= 1'b1;
                rw        <= shreg[0];
              end else begin
                st <= LS_IDLE;
              end
            end
          end
          LS_AACK: begin
            if (fall_c) begin
              cnt <= '0;
              if (rw) begin
                st        <= LS_RBIT;
                shreg     <= tx_byte_i;
                sda_low_o <= ~tx_byte_i[7];
              end else begin
                st        <= LS_WBIT;
                sda_low_o <= 1'b0;
                first     <= 1'b1;
              end
            end
          end
          LS_WBIT: begin
            if (rise_c && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (fall_c && cnt == 4'd8) begin
              st         <= LS_WACK;
              sda_low_o  <= 1'b1;
              rx_valid_o <= 1'b1;
              rx_data_o  <= shreg;
              rx_first_o <= first;
              first      <= 1'b0;
            end
          end
          LS_WACK: begin
            if (fall_c) begin
              st        <= LS_WBIT;
              cnt       <= '0;
              sda_low_o <= 1'b0;
            end
          end
          LS_RBIT: begin
            if (fall_c) begin
              if (cnt == 4'd7) begin
                st        <= LS_RACK;
                sda_low_o <= 1'b0;
                m_ack     <= 1'b0;
              end else begin
                cnt       <= cnt + 4'd1;
                shreg     <= {shreg[6:0], 1'b0};
                sda_low_o <= ~shreg[6];
              end
            end
          end
          LS_RACK: begin
            if (rise_c) begin
              if (sda_s) st <= LS_IDLE;
              else       m_ack <= 1'b1;
            end else if (fall_c && m_ack) begin
              st        <= LS_RBIT;
              cnt       <= '0;
              shreg     <= tx_byte_i;
              sda_low_o <= ~tx_byte_i[7];
              m_ack     <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: an address byte that ends while busy is never acknowledged
  p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (st == LS_ADDR && fall_c && cnt == 4'd8 && busy_i && !start_c && !stop_c)
      |=> !sda_low_o);

  // R11: a master NACK leaves SDA released
  p_release_nack_r11: assert property (@(posedge clk) disable iff (rst)
    (st == LS_RACK && rise_c && sda_s && !start_c && !stop_c) |=> !sda_low_o);

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int            CODE_W         = 7,
  parameter logic [CODE_W-1:0] IVR_DEFAULT = 7'd64,
  parameter int            NV_BUSY_CYCLES = 1500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              rx_valid_i,
  input  logic              rx_first_i,
  input  logic [7:0]        rx_data_i,
  input  logic              stop_i,
  output logic [CODE_W-1:0] wiper_o,
  output logic [7:0]        tx_byte_o,
  output logic              busy_o
);

  localparam int BW = $clog2(NV_BUSY_CYCLES + 1);

  logic [7:0]        ptr;
  logic              vol_only;
  logic [CODE_W-1:0] ivr;
  logic              nv_pend;
  logic [BW-1:0]     busy_cnt;
  logic              wr_data_evt;

  assign wr_data_evt = rx_valid_i && !rx_first_i && !busy_o;
  assign busy_o      = busy_cnt != '0;

  // Stored initial value: only power-on reset or a committing write touch it.
  always_ff @(posedge clk) begin
    if (por) begin
      ivr <= IVR_DEFAULT;
    end else if (!rst && wr_data_evt && ptr == REG_WIPER && nv_commit(vol_only)) begin
      ivr <= rx_data_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_o  <= por ? IVR_DEFAULT : ivr;
      ptr      <= '0;
      vol_only <= 1'b0;
      nv_pend  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (rx_valid_i && rx_first_i) begin
        ptr <= rx_data_i;
      end else if (wr_data_evt) begin
        case (ptr)
          REG_WIPER: begin
            wiper_o <= rx_data_i[CODE_W-1:0];
            if (nv_commit(vol_only)) nv_pend <= 1'b1;
          end
          REG_CTRL: vol_only <= rx_data_i[7];
          default: ;
        endcase
      end
      if (stop_i && nv_pend) begin
        busy_cnt <= BW'(NV_BUSY_CYCLES);
        nv_pend  <= 1'b0;
      end else if (busy_o) begin
        busy_cnt <= busy_cnt - BW'(1);
      end
    end
  end

  always_comb begin
    case (ptr)
      REG_WIPER: tx_byte_o = {{(8-CODE_W){1'b0}}, (vol_only ? wiper_o : ivr)};
      REG_CTRL:  tx_byte_o = {vol_only, 7'b0};
      default:   tx_byte_o = 8'h00;
    endcase
  end

  // R8: the wiper holds still through the busy window
  p_wiper_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(wiper_o));

  // R2: a volatile-only wiper write leaves the stored value alone
  p_ivr_kept_r2: assert property (@(posedge clk) disable iff (rst || por)
    (rx_valid_i && !rx_first_i && ptr == REG_WIPER && vol_only) |=> $stable(ivr));

endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
  parameter int TAPS   = 128,
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [TAPS-1:0]   tap_o
);

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_o[g] = (code_i == CODE_W'(g));
  end

endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl #(
  parameter int         TAPS           = 128,
  parameter logic [4:0] ADDR_HI        = 5'b01010,
  parameter int         IVR_DEFAULT    = 64,
  parameter int         NV_BUSY_CYCLES = 1500000
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_low_o,
  input  logic [1:0]               strap_i,
  output logic [$clog2(TAPS)-1:0]  wiper_o,
  output logic [TAPS-1:0]          tap_sel_o
);

  localparam int CODE_W = $clog2(TAPS);

  logic       rst, por;
  logic       busy, rx_valid, rx_first, stop_evt;
  logic [7:0] rx_data, tx_byte;

  assign por = !por_n;
  assign rst = !rst_n || por;

  dpot_i2c_link #(.ADDR_HI(ADDR_HI)) u_link (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .strap_i   (strap_i),
    .busy_i    (busy),
    .tx_byte_i (tx_byte),
    .sda_low_o (sda_low_o),
    .rx_valid_o(rx_valid),
    .rx_first_o(rx_first),
    .rx_data_o (rx_data),
    .stop_o    (stop_evt)
  );

  dpot_regs #(
    .CODE_W        (CODE_W),
    .IVR_DEFAULT   (CODE_W'(IVR_DEFAULT)),
    .NV_BUSY_CYCLES(NV_BUSY_CYCLES)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .rx_valid_i(rx_valid),
    .rx_first_i(rx_first),
    .rx_data_i (rx_data),
    .stop_i    (stop_evt),
    .wiper_o   (wiper_o),
    .tx_byte_o (tx_byte),
    .busy_o    (busy)
  );

  dpot_tap_decode #(.TAPS(TAPS), .CODE_W(CODE_W)) u_dec (
    .code_i(wiper_o),
    .tap_o (tap_sel_o)
  );

  // R10: the tap decode output is one-hot once out of reset
  p_tap_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel_o) == 1);

endmodule

// File: tb/tb_dpot_i2c_ctrl.sv
module tb_dpot_i2c_ctrl;

  localparam int Q   = 5;
  localparam int NVB = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         por_n, rst_n, scl, m_low;
  logic [1:0]   strap;
  logic         dut_low;
  logic [6:0]   wiper;
  logic [127:0] taps;
  wire          sda_bus = ~(m_low | dut_low);

  int errors = 0;
  int checks = 0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  dpot_i2c_ctrl #(.NV_BUSY_CYCLES(NVB)) dut (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_low_o(dut_low),
    .strap_i  (strap),
    .wiper_o  (wiper),
    .tap_sel_o(taps)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_taps(input string req, input int code);
    logic [127:0] e;
    e = 128'b1 << code;
    chk(taps == e, req, $countones(taps) * 1000 + int'(wiper), 1000 + code);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_rstart();
    m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    // master NACK
    m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    chk(sda_bus == 1'b1, "R11 sda released during nack", sda_bus, 1);
    tick(Q);
    scl = 1'b0; tick(Q);
    chk(dut_low == 1'b0, "R11 sda released after nack", dut_low, 0);
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {5'b01010, strap, rd};
  endfunction

  task automatic reg_write(input logic [7:0] ptr, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    i2c_start();
    send_byte(dev(1'b0), a0);
    send_byte(ptr, a1);
    send_byte(d, a2);
    i2c_stop();
    chk(a0 && a1 && a2, {req, " R1 write acks"}, {a0, a1, a2}, 3'b111);
  endtask

  // Driver side of the scoreboard: pushes the expected byte and the observed one.
  task automatic reg_read(input logic [7:0] ptr, input logic [7:0] e, input string req);
    bit a0, a1, a2;
    logic [7:0] got;
    i2c_start();
    send_byte(dev(1'b0), a0);
    send_byte(ptr, a1);
    i2c_rstart();
    send_byte(dev(1'b1), a2);
    recv_byte(got);
    i2c_stop();
    chk(a0 && a1 && a2, {req, " R1 read acks"}, {a0, a1, a2}, 3'b111);
    exp_q.push_back(e);
    tag_q.push_back(req);
    obs_q.push_back(got);
  endtask

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(o == e, t, o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    por_n = 1'b0; rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; strap = 2'b10;
    tick(5);
    por_n = 1'b1; rst_n = 1'b1;
    tick(5);

    chk(wiper == 7'd64, "R9 power-on wiper default", wiper, 64);
    chk_taps("R10 tap at default", 64);
    chk(dut_low == 1'b0, "R1 sda idle after reset", dut_low, 0);

    // R1: wrong strap value is not acknowledged
    i2c_start();
    send_byte({5'b01010, 2'b01, 1'b0}, a);
    i2c_stop();
    chk(!a, "R1 foreign address nack", a, 0);
    i2c_start();
    send_byte({5'b11010, strap, 1'b0}, a);
    i2c_stop();
    chk(!a, "R1 wrong upper bits nack", a, 0);

    // R4: control register
    reg_write(8'h02, 8'h80, "R4");
    reg_read(8'h02, 8'h80, "R4 control readback");
    reg_write(8'h02, 8'hFF, "R4");
    reg_read(8'h02, 8'h80, "R4 only bit7 kept");

    // R2: volatile-only writes
    reg_write(8'h00, 8'h15, "R2");
    chk(wiper == 7'h15, "R2 wiper updated", wiper, 8'h15);
    chk_taps("R10 tap at 15h", 8'h15);
    reg_read(8'h00, 8'h15, "R5 read wiper");
    reg_write(8'h00, 8'h00, "R10");
    chk_taps("R10 tap at 0", 0);
    reg_write(8'h00, 8'h7F, "R10");
    chk_taps("R10 tap at 127", 127);
    reg_write(8'h02, 8'h00, "R4");
    reg_read(8'h00, 8'h40, "R2 stored value unchanged");
    chk(wiper == 7'h7F, "R2 wiper still volatile value", wiper, 8'h7F);

    // R3, R6, R8: committing write, then busy window
    reg_write(8'h00, 8'hF7, "R3");
    chk(wiper == 7'h77, "R3 R6 wiper takes low 7 bits", wiper, 8'h77);
    i2c_start();
    send_byte(dev(1'b0), a);
    i2c_stop();
    chk(!a, "R8 address nack while busy", a, 0);
    chk(wiper == 7'h77, "R8 wiper unchanged while busy", wiper, 8'h77);
    tick(NVB + 50);
    reg_read(8'h00, 8'h77, "R3 R6 stored value and bit7 zero");
    chk(wiper == 7'h77, "R3 wiper after busy", wiper, 8'h77);

    // R7: undefined address
    reg_write(8'h05, 8'h33, "R7");
    reg_read(8'h05, 8'h00, "R7 undefined reads zero");
    chk(wiper == 7'h77, "R7 wiper untouched", wiper, 8'h77);
    reg_read(8'h00, 8'h77, "R7 stored value untouched");

    // R9: warm reset recall
    reg_write(8'h02, 8'h80, "R9");
    reg_write(8'h00, 8'h10, "R9");
    chk(wiper == 7'h10, "R9 volatile value set", wiper, 8'h10);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk(wiper == 7'h77, "R9 warm reset recall", wiper, 8'h77);
    reg_read(8'h02, 8'h00, "R9 control cleared by reset");

    // R9: power-on reset
    por_n = 1'b0; tick(3); por_n = 1'b1; tick(3);
    chk(wiper == 7'd64, "R9 power-on default restored", wiper, 64);
    reg_read(8'h00, 8'h40, "R9 stored default after power-on");

    tick(20);
    wait (obs_q.size() == 0);
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule